// File: doc/BRIEF.md
# Banked Data Memory Addressing Unit

This unit sits between a processor core and a 4 KB byte-wide data RAM. The RAM is organised as sixteen pages of 256 bytes each. Every access names its target in one of two ways. A direct access carries the whole 12-bit address. A banked access carries only an 8-bit in-page offset, and a 4-bit page register held inside the unit supplies the top four address bits. A separate load operation writes that page register from a literal.

A parameter mask has one bit per page and marks which pages exist as storage. Only those pages are built. A write that lands on a missing page is silently discarded. A read from a missing page returns zero. The access is still acknowledged one cycle later, exactly like a successful one.

The RAM port has one access per cycle and is read-first. Every access to a present page returns, one cycle later, the byte that was stored there before the access. The page register can be read back as a full byte with its top nibble forced to zero.

Top module: `bank_mem_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `bankRdOut` is 0x00, `ackOut` is 0 and `rdData` is 0x00.
- R2: When `bankLoadEn` is high at a clock edge, the page register takes `bankLitIn[3:0]`, and `bankLitIn[7:4]` is ignored. From the next cycle, `bankRdOut` reads {4'b0000, page}. Without a load, the page register holds its value.
- R3: With `reqDirect`=1, the target byte address is `reqAddr[11:0]`, and its page is `reqAddr[11:8]`.
- R4: With `reqDirect`=0, the target address is {page register, `reqAddr[7:0]`}, and `reqAddr[11:8]` is ignored. An access in the same cycle as a page load uses the page value from before the load.
- R5: When a request to a present page is taken at edge N, `rdData` holds that byte's previous contents from edge N until edge N+1. After any other cycle (idle, or a missing page), `rdData` is 0x00.
- R6: A write to a page whose `BANK_MASK` bit is 0 changes no stored byte. In particular, it does not alias onto a present page with the same offset.
- R7: A read or write aimed at a missing page, whether direct or banked, returns `rdData` = 0x00 in the following cycle.
- R8: `ackOut` is high in exactly the cycle after each cycle with `reqValid`=1, whether or not the page is present. Otherwise it is low.
- R9: A write to a present page returns the old contents of the byte in `rdData`. A later read returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | An access is requested this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqDirect | input | 1 | 1 = full 12-bit address, 0 = page register plus offset |
| reqAddr | input | 12 | Address; only bits 7:0 are used in banked mode |
| reqWData | input | 8 | Write data |
| bankLoadEn | input | 1 | Load the page register from the literal |
| bankLitIn | input | 8 | Literal for the page register; bits 7:4 are ignored |
| bankRdOut | output | 8 | Page register read-back, top nibble zero |
| rdData | output | 8 | Read data, one cycle after the access |
| ackOut | output | 1 | Completion, one cycle after each request |

## Verification
The bench targets several corner cases.
- It writes a missing page at an offset already used on a present page, then reads the present page back. A design that decoded only the offset, or folded the page index, would overwrite that byte.
- It loads the page register with a literal whose top nibble is set. A design that stored all eight bits would show a nonzero top nibble or select the wrong page.
- It loads the page register in the same cycle as a banked write. A design that forwarded the new page would place the byte at the wrong address.
- It writes over a known byte and back-to-back reads check read-first timing and single-cycle latency. A write-first or unregistered port would return the new data early.
- Accesses to missing pages must still raise the acknowledge and return zero rather than stale slice data.

// File: rtl/bank_mem_pkg.sv
package bank_mem_pkg;
  parameter int BANK_W = 4;
  parameter int OFF_W  = 8;
  parameter int DATA_W = 8;
  localparam int ADDR_W    = BANK_W + OFF_W;
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int BANK_DEPTH = 1 << OFF_W;

  // strobes handed from control to datapath
  typedef struct packed {
    logic              hit;    // valid access to a present page
    logic              write;
    logic [BANK_W-1:0] bank;
    logic [OFF_W-1:0]  offset;
  } memStrobe_t;
endpackage

// File: rtl/bank_ram_slice.sv
module bank_ram_slice
  import bank_mem_pkg::*;
(
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [OFF_W-1:0]  addr,
  input  logic [DATA_W-1:0] wData,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [BANK_DEPTH];

  // read-first: q gets the contents before this cycle's write
  always_ff @(posedge clk) begin
    if (en) begin
      q <= mem[addr];
      if (we) mem[addr] <= wData;
    end
  end
endmodule

// File: rtl/bank_mem_ctrl.sv
module bank_mem_ctrl
  import bank_mem_pkg::*;
#(
  parameter logic [NUM_BANKS-1:0] BANK_MASK = 16'h80FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqDirect,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              bankLoadEn,
  input  logic [DATA_W-1:0] bankLitIn,
  output logic [DATA_W-1:0] bankRdOut,
  output logic              ackOut,
  output memStrobe_t        strb
);
  logic [BANK_W-1:0] bankReg;
  logic [BANK_W-1:0] selBank;
  logic              ackQ;
  logic              unusedLitBits;

  assign unusedLitBits = ^bankLitIn[DATA_W-1:BANK_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankReg <= '0;
      ackQ    <= 1'b0;
    end else begin
      if (bankLoadEn) bankReg <= bankLitIn[BANK_W-1:0];
      ackQ <= reqValid;
    end
  end

  always_comb begin
    selBank     = reqDirect ? reqAddr[ADDR_W-1 -: BANK_W] : bankReg;
    strb.bank   = selBank;
    strb.offset = reqAddr[OFF_W-1:0];
    strb.write  = reqWrite;
    strb.hit    = reqValid & BANK_MASK[selBank];
  end

  assign bankRdOut = {{(DATA_W-BANK_W){1'b0}}, bankReg};
  assign ackOut    = ackQ;
endmodule

// File: rtl/bank_mem_datapath.sv
module bank_mem_datapath
  import bank_mem_pkg::*;
#(
  parameter logic [NUM_BANKS-1:0] BANK_MASK = 16'h80FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strb,
  input  logic [DATA_W-1:0] reqWData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] sliceQ [NUM_BANKS];
  logic              rdHitQ;
  logic [BANK_W-1:0] rdBankQ;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    if (BANK_MASK[b]) begin : g_present
      logic sel;
      assign sel = strb.hit && (strb.bank == BANK_W'(b));
      bank_ram_slice u_slice (
        .clk  (clk),
        .en   (sel),
        .we   (sel & strb.write),
        .addr (strb.offset),
        .wData(reqWData),
        .q    (sliceQ[b])
      );
    end else begin : g_absent
      assign sliceQ[b] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdHitQ  <= 1'b0;
      rdBankQ <= '0;
    end else begin
      rdHitQ  <= strb.hit;
      rdBankQ <= strb.bank;
    end
  end

  assign rdData = rdHitQ ? sliceQ[rdBankQ] : '0;
endmodule

// File: rtl/bank_mem_unit.sv
module bank_mem_unit
  import bank_mem_pkg::*;
#(
  parameter logic [NUM_BANKS-1:0] BANK_MASK = 16'h80FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqDirect,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  input  logic              bankLoadEn,
  input  logic [DATA_W-1:0] bankLitIn,
  output logic [DATA_W-1:0] bankRdOut,
  output logic [DATA_W-1:0] rdData,
  output logic              ackOut
);
  memStrobe_t strb;

  bank_mem_ctrl #(.BANK_MASK(BANK_MASK)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqDirect (reqDirect),
    .reqAddr   (reqAddr),
    .bankLoadEn(bankLoadEn),
    .bankLitIn (bankLitIn),
    .bankRdOut (bankRdOut),
    .ackOut    (ackOut),
    .strb      (strb)
  );

  bank_mem_datapath #(.BANK_MASK(BANK_MASK)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqWData(reqWData),
    .rdData  (rdData)
  );
endmodule

// File: rtl/bank_mem_checker.sv
module bank_mem_checker
  import bank_mem_pkg::*;
#(
  parameter logic [NUM_BANKS-1:0] BANK_MASK = 16'h80FF
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqDirect,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              bankLoadEn,
  input logic [DATA_W-1:0] bankLitIn,
  input logic [DATA_W-1:0] bankRdOut,
  input logic [DATA_W-1:0] rdData,
  input logic              ackOut
);
  p_ack_follows_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> ackOut);

  p_no_spurious_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !ackOut);

  p_bank_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    bankLoadEn |=> (bankRdOut == {{(DATA_W-BANK_W){1'b0}}, $past(bankLitIn[BANK_W-1:0])}));

  p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !bankLoadEn |=> $stable(bankRdOut));

  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (rdData == '0));

  p_direct_absent_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqDirect && !BANK_MASK[reqAddr[ADDR_W-1 -: BANK_W]]) |=> (rdData == '0));

  p_banked_absent_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqDirect && !BANK_MASK[bankRdOut[BANK_W-1:0]]) |=> (rdData == '0));
endmodule

bind bank_mem_unit bank_mem_checker #(.BANK_MASK(BANK_MASK)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqDirect (reqDirect),
  .reqAddr   (reqAddr),
  .bankLoadEn(bankLoadEn),
  .bankLitIn (bankLitIn),
  .bankRdOut (bankRdOut),
  .rdData    (rdData),
  .ackOut    (ackOut)
);

// File: tb/tb_bank_mem_unit.sv
module tb_bank_mem_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqDirect = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [7:0]  reqWData = '0;
  logic        bankLoadEn = 1'b0;
  logic [7:0]  bankLitIn = '0;
  logic [7:0]  bankRdOut, rdData;
  logic        ackOut;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bank_mem_unit dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqDirect(reqDirect), .reqAddr(reqAddr), .reqWData(reqWData),
    .bankLoadEn(bankLoadEn), .bankLitIn(bankLitIn), .bankRdOut(bankRdOut),
    .rdData(rdData), .ackOut(ackOut)
  );

  // default mask: pages 0..7 and 15 present, 8..14 missing
  // fields: [30] write, [29] direct, [28] check rdData, [27:16] addr, [15:8] wdata, [7:0] expected
  localparam logic [30:0] VEC [12] = '{
    {1'b1, 1'b1, 1'b0, 12'h010, 8'hA5, 8'h00},  // R3 write page 0
    {1'b1, 1'b0, 1'b0, 12'hF22, 8'h3C, 8'h00},  // R4 banked, page 3 -> 0x322
    {1'b0, 1'b1, 1'b1, 12'h010, 8'h00, 8'hA5},  // R3 R5 read back
    {1'b0, 1'b1, 1'b1, 12'h322, 8'h00, 8'h3C},  // R4 landed at 0x322
    {1'b0, 1'b0, 1'b1, 12'h522, 8'h00, 8'h3C},  // R4 upper addr bits ignored
    {1'b1, 1'b1, 1'b1, 12'h322, 8'h77, 8'h3C},  // R9 write returns old byte
    {1'b0, 1'b1, 1'b1, 12'h322, 8'h00, 8'h77},  // R9 new byte visible
    {1'b1, 1'b1, 1'b1, 12'h910, 8'hEE, 8'h00},  // R7 write to missing page
    {1'b0, 1'b1, 1'b1, 12'h910, 8'h00, 8'h00},  // R7 read missing page
    {1'b1, 1'b1, 1'b1, 12'h810, 8'h11, 8'h00},  // R6 missing page, offset 0x10
    {1'b0, 1'b1, 1'b1, 12'h010, 8'h00, 8'hA5},  // R6 page 0 byte untouched
    {1'b1, 1'b1, 1'b0, 12'hFFF, 8'h5A, 8'h00}   // R3 top page write
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one access, then outputs are sampled at the negedge after the capturing edge
  task automatic access(input logic w, input logic d, input logic [11:0] a, input logic [7:0] wd);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqDirect = d; reqAddr = a; reqWData = wd;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic loadBank(input logic [7:0] lit);
    @(negedge clk);
    bankLoadEn = 1'b1; bankLitIn = lit;
    @(negedge clk);
    bankLoadEn = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 bankRdOut in reset", bankRdOut, 8'h00);
    chk("R1 ackOut in reset", {7'b0, ackOut}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 rdData after reset", rdData, 8'h00);
    chk("R1 bankRdOut after reset", bankRdOut, 8'h00);

    loadBank(8'hF3);
    chk("R2 literal upper nibble ignored", bankRdOut, 8'h03);

    for (int i = 0; i < 12; i++) begin
      access(VEC[i][30], VEC[i][29], VEC[i][27:16], VEC[i][15:8]);
      chk($sformatf("R8 ack on table vector %0d", i), {7'b0, ackOut}, 8'h01);
      if (VEC[i][28])
        chk($sformatf("table vector %0d (R3 R4 R5 R6 R7 R9)", i), rdData, VEC[i][7:0]);
      @(negedge clk);
      chk("R8 no ack when idle", {7'b0, ackOut}, 8'h00);
      chk("R5 rdData zero after idle", rdData, 8'h00);
    end

    access(1'b0, 1'b1, 12'hFFF, 8'h00);
    chk("R3 top page read", rdData, 8'h5A);

    // R2 hold and new load
    @(negedge clk);
    chk("R2 page register holds", bankRdOut, 8'h03);
    loadBank(8'hA7);
    chk("R2 load 0xA7", bankRdOut, 8'h07);

    // R4 banked write into page 7
    access(1'b1, 1'b0, 12'h040, 8'h5C);
    access(1'b0, 1'b1, 12'h740, 8'h00);
    chk("R4 banked write at 0x740", rdData, 8'h5C);

    // R4 load in the same cycle as a banked write uses the old page
    @(negedge clk);
    bankLoadEn = 1'b1; bankLitIn = 8'h02;
    reqValid = 1'b1; reqWrite = 1'b1; reqDirect = 1'b0; reqAddr = 12'h041; reqWData = 8'h99;
    @(negedge clk);
    bankLoadEn = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    chk("R2 same-cycle load applied", bankRdOut, 8'h02);
    access(1'b0, 1'b1, 12'h741, 8'h00);
    chk("R4 same-cycle write used old page", rdData, 8'h99);

    // R5 back-to-back reads, one cycle latency each
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqDirect = 1'b1; reqAddr = 12'h010;
    @(negedge clk);
    chk("R5 first back-to-back read", rdData, 8'hA5);
    reqAddr = 12'h740;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R5 second back-to-back read", rdData, 8'h5C);
    @(negedge clk);
    chk("R5 zero after back-to-back", rdData, 8'h00);

    // R7 banked access to a missing page
    loadBank(8'h0C);
    access(1'b0, 1'b0, 12'h010, 8'h00);
    chk("R7 banked read of missing page", rdData, 8'h00);
    chk("R8 ack for missing page", {7'b0, ackOut}, 8'h01);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule